// File: doc/BRIEF.md
# Interrupt Context Switch Sequencer

This block performs the processor's context switch when an interrupt is taken or a service routine returns. When the priority logic upstream hands it the index of a source that has been acknowledged, the sequencer saves the program counter as two bytes on an upward-growing stack. It also moves the global interrupt enable into a saved-enable bit and clears the live enable. It then reads the 16-bit service address from that source's vector slot and loads it into the program counter.

Two return commands pop the program counter back off the stack. The interrupt return also sets the global enable again, but only when the saved-enable bit is 1. The plain return leaves the enable as it is. When reset is released, the sequencer skips stacking and fetches the start address from the top word of the address space.

Memory access goes through a simple synchronous byte port, and read data arrives one cycle after the request. Instruction decode and the choice between competing interrupts are handled outside this block.

Top module: `isr_context_seq`

## Requirements
- R1: While reset is asserted and after it is released, the sequencer writes nothing. It reads the bytes at FFFE (low) and FFFF (high) hex and loads them into the program counter. The stack pointer is set to its reset value and both enable bits are cleared.
- R2: An accepted acknowledge writes pc[7:0] at the stack pointer address and pc[15:8] at the next address. The stack pointer then rises by two. Reads and writes are never requested in the same cycle.
- R3: In the cycle an acknowledge is accepted, the saved-enable bit takes the value of the global enable, and the global enable is cleared.
- R4: The vector slot for source index i is the word at FFFE - 2*i. Its low byte is at that address and its high byte at the next. After stacking, the program counter is loaded with that word.
- R5: Busy is high for exactly five cycles after an acknowledge is accepted. While busy is high, acknowledges and both return commands are ignored.
- R6: An interrupt return subtracts two from the stack pointer and loads the program counter from the popped word, low byte at the lower address. It sets the global enable only if the saved-enable bit is 1; otherwise the enable is left unchanged.
- R7: A plain return pops the program counter in the same way and leaves the global enable unchanged.
- R8: A global-enable write while idle sets the enable. This lets a service routine allow a nested entry, and that nested entry then saves an enable of 1.
- R9: If commands arrive together, an acknowledge takes priority over both returns, and an interrupt return takes priority over a plain return.
- R10: The program counter changes only at the end of a sequence or through a program-counter write while idle with no other command present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ack_valid | input | 1 | An acknowledged interrupt is presented |
| ack_idx | input | SW | Rank index of the acknowledged source |
| ret_irq | input | 1 | Interrupt return command (restores enable) |
| ret_plain | input | 1 | Plain return command |
| pc_wr | input | 1 | Write the program counter while idle |
| pc_wdata | input | AW | New program counter value |
| gie_wr | input | 1 | Write the global enable while idle |
| gie_wdata | input | 1 | New global enable value |
| busy | output | 1 | A sequence is in progress |
| pc | output | AW | Program counter |
| sp | output | AW | Stack pointer |
| gie | output | 1 | Global interrupt enable |
| gie_saved | output | 1 | Enable value saved at the last entry |
| mem_addr | output | AW | Byte address of the memory request |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read strobe; data returns next cycle |
| mem_wdata | output | AW/2 | Write byte |
| mem_rdata | input | AW/2 | Read byte, one cycle after mem_re |

## Verification
The bench nests one entry inside another and checks that the inner entry saves an enable of 1. A design that copied the enable after clearing it would save 0, and the outer return would then leave interrupts disabled. It runs an interrupt return with the saved bit at 0, which catches a design that always sets the enable. It also reads back the stacked bytes to catch a byte-order swap or a one-byte stack step.

The bench offers an acknowledge and a return in the middle of a busy sequence. A design that accepted either would disturb the stack pointer or load the wrong vector. It asserts reset partway through an entry, which exposes a design that stacks on reset or loses the top vector. It also presents commands at the same time to check their priority.

// File: rtl/isr_pkg.sv
package isr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_PUSH_LO  = 3'd1,
        ST_PUSH_HI  = 3'd2,
        ST_FETCH_LO = 3'd3,
        ST_FETCH_HI = 3'd4,
        ST_POP_LO   = 3'd5,
        ST_POP_HI   = 3'd6,
        ST_LOAD     = 3'd7
    } seq_state_e;

endpackage

// File: rtl/isr_slot_calc.sv
module isr_slot_calc #(
    parameter int AW = 16,
    parameter int SW = 3
) (
    input  logic [SW-1:0] idx,
    output logic [AW-1:0] slot
);
    localparam logic [AW-1:0] TOP_SLOT = {{(AW-1){1'b1}}, 1'b0};

    always_comb begin
        slot = TOP_SLOT - (AW'(idx) << 1);
    end
endmodule

// File: rtl/isr_port_drv.sv
module isr_port_drv #(
    parameter int AW = 16
) (
    input  isr_pkg::seq_state_e st,
    input  logic [AW-1:0]       sp,
    input  logic [AW-1:0]       pc,
    input  logic [AW-1:0]       slot,
    output logic [AW-1:0]       mem_addr,
    output logic                mem_we,
    output logic                mem_re,
    output logic [AW/2-1:0]     mem_wdata
);
    import isr_pkg::*;
    localparam int DW = AW / 2;
    localparam logic [AW-1:0] ONE = AW'(1);

    always_comb begin
        mem_addr  = '0;
        mem_we    = 1'b0;
        mem_re    = 1'b0;
        mem_wdata = '0;
        case (st)
            ST_PUSH_LO: begin
                mem_we    = 1'b1;
                mem_addr  = sp;
                mem_wdata = pc[DW-1:0];
            end
            ST_PUSH_HI: begin
                mem_we    = 1'b1;
                mem_addr  = sp + ONE;
                mem_wdata = pc[AW-1:DW];
            end
            ST_FETCH_LO: begin
                mem_re   = 1'b1;
                mem_addr = slot;
            end
            ST_FETCH_HI: begin
                mem_re   = 1'b1;
                mem_addr = slot + ONE;
            end
            ST_POP_LO: begin
                mem_re   = 1'b1;
                mem_addr = sp;
            end
            ST_POP_HI: begin
                mem_re   = 1'b1;
                mem_addr = sp + ONE;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/isr_ctx_fsm.sv
module isr_ctx_fsm #(
    parameter int            AW       = 16,
    parameter logic [AW-1:0] SP_RESET = 16'h0100
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ack_valid,
    input  logic [AW-1:0]       ack_slot,
    input  logic                ret_irq,
    input  logic                ret_plain,
    input  logic                pc_wr,
    input  logic [AW-1:0]       pc_wdata,
    input  logic                gie_wr,
    input  logic                gie_wdata,
    input  logic [AW/2-1:0]     mem_rdata,
    output isr_pkg::seq_state_e st,
    output logic [AW-1:0]       pc,
    output logic [AW-1:0]       sp,
    output logic [AW-1:0]       slot,
    output logic                gie,
    output logic                gie_saved
);
    import isr_pkg::*;
    localparam int DW = AW / 2;
    localparam logic [AW-1:0] TWO      = AW'(2);
    localparam logic [AW-1:0] TOP_SLOT = {{(AW-1){1'b1}}, 1'b0};

    typedef struct packed {
        seq_state_e    st;
        logic [AW-1:0] pc;
        logic [AW-1:0] sp;
        logic [AW-1:0] slot;
        logic [DW-1:0] lo;
        logic          gie;
        logic          sv;
        logic          reti;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        case (r_q.st)
            ST_IDLE: begin
                if (ack_valid) begin
                    r_d.sv   = r_q.gie;
                    r_d.gie  = 1'b0;
                    r_d.slot = ack_slot;
                    r_d.st   = ST_PUSH_LO;
                end else if (ret_irq || ret_plain) begin
                    r_d.sp   = r_q.sp - TWO;
                    r_d.reti = ret_irq;
                    r_d.st   = ST_POP_LO;
                end else begin
                    if (pc_wr)  r_d.pc  = pc_wdata;
                    if (gie_wr) r_d.gie = gie_wdata;
                end
            end
            ST_PUSH_LO:  r_d.st = ST_PUSH_HI;
            ST_PUSH_HI: begin
                r_d.sp   = r_q.sp + TWO;
                r_d.reti = 1'b0;
                r_d.st   = ST_FETCH_LO;
            end
            ST_FETCH_LO: r_d.st = ST_FETCH_HI;
            ST_FETCH_HI: begin
                r_d.lo = mem_rdata;
                r_d.st = ST_LOAD;
            end
            ST_POP_LO:   r_d.st = ST_POP_HI;
            ST_POP_HI: begin
                r_d.lo = mem_rdata;
                r_d.st = ST_LOAD;
            end
            ST_LOAD: begin
                r_d.pc = {mem_rdata, r_q.lo};
                if (r_q.reti && r_q.sv) r_d.gie = 1'b1;
                r_d.reti = 1'b0;
                r_d.st   = ST_IDLE;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st   <= ST_FETCH_LO;
            r_q.pc   <= '0;
            r_q.sp   <= SP_RESET;
            r_q.slot <= TOP_SLOT;
            r_q.lo   <= '0;
            r_q.gie  <= 1'b0;
            r_q.sv   <= 1'b0;
            r_q.reti <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign st        = r_q.st;
    assign pc        = r_q.pc;
    assign sp        = r_q.sp;
    assign slot      = r_q.slot;
    assign gie       = r_q.gie;
    assign gie_saved = r_q.sv;
endmodule

// File: rtl/isr_context_seq.sv
module isr_context_seq #(
    parameter int            AW       = 16,
    parameter int            SW       = 3,
    parameter logic [AW-1:0] SP_RESET = 16'h0100
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ack_valid,
    input  logic [SW-1:0]   ack_idx,
    input  logic            ret_irq,
    input  logic            ret_plain,
    input  logic            pc_wr,
    input  logic [AW-1:0]   pc_wdata,
    input  logic            gie_wr,
    input  logic            gie_wdata,
    output logic            busy,
    output logic [AW-1:0]   pc,
    output logic [AW-1:0]   sp,
    output logic            gie,
    output logic            gie_saved,
    output logic [AW-1:0]   mem_addr,
    output logic            mem_we,
    output logic            mem_re,
    output logic [AW/2-1:0] mem_wdata,
    input  logic [AW/2-1:0] mem_rdata
);
    import isr_pkg::*;

    seq_state_e    st;
    logic [AW-1:0] ack_slot;
    logic [AW-1:0] slot;

    isr_slot_calc #(.AW(AW), .SW(SW)) u_slot (
        .idx  (ack_idx),
        .slot (ack_slot)
    );

    isr_ctx_fsm #(.AW(AW), .SP_RESET(SP_RESET)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .ack_valid (ack_valid),
        .ack_slot  (ack_slot),
        .ret_irq   (ret_irq),
        .ret_plain (ret_plain),
        .pc_wr     (pc_wr),
        .pc_wdata  (pc_wdata),
        .gie_wr    (gie_wr),
        .gie_wdata (gie_wdata),
        .mem_rdata (mem_rdata),
        .st        (st),
        .pc        (pc),
        .sp        (sp),
        .slot      (slot),
        .gie       (gie),
        .gie_saved (gie_saved)
    );

    isr_port_drv #(.AW(AW)) u_port (
        .st        (st),
        .sp        (sp),
        .pc        (pc),
        .slot      (slot),
        .mem_addr  (mem_addr),
        .mem_we    (mem_we),
        .mem_re    (mem_re),
        .mem_wdata (mem_wdata)
    );

    assign busy = (st != ST_IDLE);
endmodule

// File: rtl/isr_context_checks.sv
module isr_context_checks #(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ack_valid,
    input logic          ret_irq,
    input logic          ret_plain,
    input logic          pc_wr,
    input logic          gie_wr,
    input logic          busy,
    input logic [AW-1:0] pc,
    input logic [AW-1:0] sp,
    input logic          gie,
    input logic          gie_saved,
    input logic          mem_we,
    input logic          mem_re
);
    localparam logic [AW-1:0] TWO = AW'(2);

    a_r2_no_rw_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we && mem_re));

    a_r1_write_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> busy);

    a_r2_sp_steps_by_two: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sp) |-> ((sp - $past(sp)) == TWO || ($past(sp) - sp) == TWO));

    a_r3_entry_saves_gie: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_valid && !busy) |=> (!gie && gie_saved == $past(gie)));

    a_r10_pc_change_points: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pc) |-> ($fell(busy) ||
            $past(pc_wr && !busy && !ack_valid && !ret_irq && !ret_plain)));

    a_r6_gie_rise_points: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gie) |-> ($fell(busy) ||
            $past(gie_wr && !busy && !ack_valid && !ret_irq && !ret_plain)));
endmodule

bind isr_context_seq isr_context_checks #(.AW(AW)) u_checks (
    .clk       (clk),
    .rst_n     (rst_n),
    .ack_valid (ack_valid),
    .ret_irq   (ret_irq),
    .ret_plain (ret_plain),
    .pc_wr     (pc_wr),
    .gie_wr    (gie_wr),
    .busy      (busy),
    .pc        (pc),
    .sp        (sp),
    .gie       (gie),
    .gie_saved (gie_saved),
    .mem_we    (mem_we),
    .mem_re    (mem_re)
);

// File: tb/test_isr_context_seq.sv
module test_isr_context_seq;
    localparam int AW = 16;
    localparam int SW = 3;
    localparam logic [2:0] OP_GIE = 3'd0, OP_PC = 3'd1, OP_ACK = 3'd2,
                           OP_RETI = 3'd3, OP_RET = 3'd4;
    // step: op[52:50] arg[49:34] pc[33:18] sp[17:2] gie[1] saved[0]
    localparam int NSTEP = 11;
    localparam logic [52:0] STEPS [0:NSTEP-1] = '{
        {OP_GIE,  16'h0001, 16'h4000, 16'h0100, 1'b1, 1'b0},
        {OP_PC,   16'h1234, 16'h1234, 16'h0100, 1'b1, 1'b0},
        {OP_ACK,  16'h0003, 16'h4333, 16'h0102, 1'b0, 1'b1},
        {OP_GIE,  16'h0001, 16'h4333, 16'h0102, 1'b1, 1'b1},
        {OP_ACK,  16'h0005, 16'h4555, 16'h0104, 1'b0, 1'b1},
        {OP_RETI, 16'h0000, 16'h4333, 16'h0102, 1'b1, 1'b1},
        {OP_RET,  16'h0000, 16'h1234, 16'h0100, 1'b1, 1'b1},
        {OP_ACK,  16'h0001, 16'h4111, 16'h0102, 1'b0, 1'b1},
        {OP_ACK,  16'h0007, 16'h4777, 16'h0104, 1'b0, 1'b0},
        {OP_RETI, 16'h0000, 16'h4111, 16'h0102, 1'b0, 1'b0},
        {OP_RET,  16'h0000, 16'h1234, 16'h0100, 1'b0, 1'b0}
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic ack_valid = 0, ret_irq = 0, ret_plain = 0, pc_wr = 0, gie_wr = 0, gie_wdata = 0;
    logic [SW-1:0] ack_idx = '0;
    logic [AW-1:0] pc_wdata = '0;
    logic busy, gie, gie_saved, mem_we, mem_re;
    logic [AW-1:0] pc, sp, mem_addr;
    logic [7:0] mem_wdata, mem_rdata;
    logic [7:0] stk [0:255];
    logic [7:0] vtab [0:255];
    int checks = 0, errors = 0, wr_cnt = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    isr_context_seq #(.AW(AW), .SW(SW)) i_isr_context_seq (
        .clk(clk), .rst_n(rst_n), .ack_valid(ack_valid), .ack_idx(ack_idx),
        .ret_irq(ret_irq), .ret_plain(ret_plain), .pc_wr(pc_wr), .pc_wdata(pc_wdata),
        .gie_wr(gie_wr), .gie_wdata(gie_wdata), .busy(busy), .pc(pc), .sp(sp),
        .gie(gie), .gie_saved(gie_saved), .mem_addr(mem_addr), .mem_we(mem_we),
        .mem_re(mem_re), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    // byte memory: FF00..FFFF vector area, everything else folds into a 256-byte stack
    always @(posedge clk) begin
        if (mem_we) begin
            wr_cnt <= wr_cnt + 1;
            if (mem_addr >= 16'hFF00) vtab[mem_addr[7:0]] <= mem_wdata;
            else                      stk[mem_addr[7:0]]  <= mem_wdata;
        end
        if (mem_re)
            mem_rdata <= (mem_addr >= 16'hFF00) ? vtab[mem_addr[7:0]] : stk[mem_addr[7:0]];
    end

    function automatic logic [15:0] vec_word(input int i);
        return 16'h4000 + 16'(i) * 16'h0111;
    endfunction

    initial begin
        mem_rdata = '0;
        for (int k = 0; k < 256; k++) begin
            stk[k]  = 8'h00;
            vtab[k] = 8'h00;
        end
        for (int i = 0; i < 8; i++) begin
            vtab[8'hFE - 2*i] = vec_word(i)[7:0];
            vtab[8'hFF - 2*i] = vec_word(i)[15:8];
        end
    end

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    task automatic run_op(input logic [2:0] op, input logic [15:0] arg);
        @(negedge clk);
        case (op)
            OP_GIE:  begin gie_wr = 1; gie_wdata = arg[0]; end
            OP_PC:   begin pc_wr = 1; pc_wdata = arg; end
            OP_ACK:  begin ack_valid = 1; ack_idx = arg[SW-1:0]; end
            OP_RETI: ret_irq = 1;
            default: ret_plain = 1;
        endcase
        @(negedge clk);
        {gie_wr, pc_wr, ack_valid, ret_irq, ret_plain} = '0;
        wait_idle();
    endtask

    function automatic string req_of(input logic [2:0] op);
        case (op)
            OP_GIE:  return "R8";
            OP_PC:   return "R10";
            OP_ACK:  return "R4/R3";
            OP_RETI: return "R6";
            default: return "R7";
        endcase
    endfunction

    initial begin
        int busy_cycles;
        int wr_before;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", "busy in reset", {31'd0, busy}, 32'd1);
        chk("R1", "sp in reset", {16'd0, sp}, 32'h0100);
        rst_n = 1;
        wait_idle();
        chk("R1", "pc from top vector", {16'd0, pc}, 32'h4000);
        chk("R1", "gie after reset", {31'd0, gie}, 32'd0);
        chk("R1", "saved after reset", {31'd0, gie_saved}, 32'd0);
        chk("R1", "no writes on reset", wr_cnt, 32'd0);

        for (int s = 0; s < NSTEP; s++) begin
            run_op(STEPS[s][52:50], STEPS[s][49:34]);
            chk(req_of(STEPS[s][52:50]), $sformatf("step %0d pc", s), {16'd0, pc}, {16'd0, STEPS[s][33:18]});
            chk(req_of(STEPS[s][52:50]), $sformatf("step %0d sp", s), {16'd0, sp}, {16'd0, STEPS[s][17:2]});
            chk(req_of(STEPS[s][52:50]), $sformatf("step %0d gie", s), {31'd0, gie}, {31'd0, STEPS[s][1]});
            chk(req_of(STEPS[s][52:50]), $sformatf("step %0d saved", s), {31'd0, gie_saved}, {31'd0, STEPS[s][0]});
        end

        // R2: stacked byte order (pushes of 1234 at 0100 and 4111 at 0102)
        chk("R2", "stack byte 0", {24'd0, stk[0]}, 32'h34);
        chk("R2", "stack byte 1", {24'd0, stk[1]}, 32'h12);
        chk("R2", "stack byte 2", {24'd0, stk[2]}, 32'h11);
        chk("R2", "stack byte 3", {24'd0, stk[3]}, 32'h41);

        // R9: acknowledge beats both returns, interrupt return beats plain return
        run_op(OP_GIE, 16'h0001);
        @(negedge clk);
        ack_valid = 1; ack_idx = 3'd2; ret_irq = 1; ret_plain = 1;
        @(negedge clk);
        {ack_valid, ret_irq, ret_plain} = '0;
        wait_idle();
        chk("R9", "ack wins sp", {16'd0, sp}, 32'h0102);
        chk("R9", "ack wins pc", {16'd0, pc}, 32'h4222);
        @(negedge clk);
        ret_irq = 1; ret_plain = 1;
        @(negedge clk);
        {ret_irq, ret_plain} = '0;
        wait_idle();
        chk("R9", "reti wins gie", {31'd0, gie}, 32'd1);
        chk("R9", "reti wins pc", {16'd0, pc}, 32'h1234);

        // R5: busy length and commands ignored while busy
        @(negedge clk);
        ack_valid = 1; ack_idx = 3'd4;
        @(negedge clk);
        ack_valid = 0;
        busy_cycles = 0;
        while (busy) begin
            busy_cycles++;
            if (busy_cycles == 2) begin ack_valid = 1; ack_idx = 3'd6; ret_plain = 1; end
            else begin ack_valid = 0; ret_plain = 0; end
            @(negedge clk);
        end
        {ack_valid, ret_plain} = '0;
        chk("R5", "busy cycles", busy_cycles, 32'd5);
        repeat (2) @(negedge clk);
        chk("R5", "busy stays low", {31'd0, busy}, 32'd0);
        chk("R5", "pc not disturbed", {16'd0, pc}, 32'h4444);
        chk("R5", "sp not disturbed", {16'd0, sp}, 32'h0102);

        // R1: reset partway through an entry
        @(negedge clk);
        ack_valid = 1; ack_idx = 3'd2;
        @(negedge clk);
        ack_valid = 0;
        @(negedge clk);
        rst_n = 0;
        repeat (2) @(negedge clk);
        wr_before = wr_cnt;
        rst_n = 1;
        wait_idle();
        chk("R1", "pc after mid reset", {16'd0, pc}, 32'h4000);
        chk("R1", "sp after mid reset", {16'd0, sp}, 32'h0100);
        chk("R1", "gie after mid reset", {31'd0, gie}, 32'd0);
        chk("R1", "no stacking on reset", wr_cnt - wr_before, 32'd0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule